// File: doc/BRIEF.md
# Single-Cycle RISC Subset Core

This block is a 32-bit processor core that completes one instruction per clock cycle. It decodes seven instructions: register add and subtract, OR with an immediate, word load and store, branch on equal, and absolute jump. Within the block sit a main decoder, a register bank of 32 words, an immediate extender, a three-operation ALU, next-address logic, and small local arrays for instructions and data.

Instruction words are loaded through a write port while the core is held in reset. After reset is released, the core fetches from address 0. Two debug views are visible at the ports. The first is the address of the instruction now executing. The second is the register write that this instruction will commit at the next rising edge. No other bus leaves the block.

Top module: `rcore_top`

## Requirements
- R1: An instruction with opcode bits [31:26] = 000000 and function bits [5:0] = 100000 writes rs+rt into register rd. Function 100010 writes rs-rt into rd. The register fields are rs [25:21], rt [20:16] and rd [15:11], and the arithmetic wraps modulo 2^32.
- R2: Opcode 001101 writes rs OR the zero-filled immediate [15:0] into register rt.
- R3: Opcode 100011 loads into rt the data word at byte address rs + sign-filled immediate. Opcode 101011 stores rt at that address and writes no register. The word index is the address bits [log2(DMEM_WORDS)+1:2].
- R4: A data address with any bit set above the word index has no effect when it is a store. Such an address reads as zero when it is a load.
- R5: Opcode 000100 writes nothing. When rs equals rt, the next PC is PC+4 plus the sign-filled immediate shifted left by two. Otherwise the next PC is PC+4.
- R6: Opcode 000010 writes nothing and sets the next PC to {PC[31:28], target [25:0], 2'b00}.
- R7: Register 0 always reads as zero, and a write aimed at it is dropped. The debug port still reports that write attempt.
- R8: Any other opcode, or an opcode-000000 word with any other function code, writes neither a register nor memory, and advances the PC by 4.
- R9: While rst_n is low, dbg_pc is 0 and no write occurs. After rst_n rises, the core stays idle at PC 0 through one more rising edge. It executes the word at address 0 in the cycle that follows the second rising edge.
- R10: dbg_pc shows the address of the instruction now executing. dbg_wr_en, dbg_wr_idx and dbg_wr_data show that instruction's register write, which is committed at the next rising edge.
- R11: When imem_we is high at a rising edge, imem_wdata is stored at the instruction word index imem_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| imem_we | input | 1 | Instruction array write strobe |
| imem_addr | input | $clog2(IMEM_WORDS) | Instruction word index to write |
| imem_wdata | input | 32 | Instruction word to write |
| dbg_pc | output | 32 | Address of the executing instruction |
| dbg_wr_en | output | 1 | Executing instruction writes a register |
| dbg_wr_idx | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
The bench builds the core with IMEM_WORDS = 32 and DMEM_WORDS = 16. With these values the data array ends at byte 0x3C, so a single 16-bit offset can land exactly one word past the end. One program can therefore check that an out-of-range load reads zero and that an out-of-range store, whose low index bits alias a live word, leaves that word intact. The program holds both a forward and a backward branch, a skipped jump region and a self-loop within 24 words. Sign-filled memory offsets are made observable because an address extended with zeros instead of sign bits falls outside the array.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  // One bundle of datapath steering produced per instruction word.
  typedef struct packed {
    logic    wr_rd;     // destination taken from rd instead of rt
    logic    use_imm;   // second ALU operand is the extended immediate
    logic    load_sel;  // write-back value comes from data array
    logic    reg_we;    // register bank write
    logic    mem_we;    // data array write
    logic    branch;    // conditional PC-relative redirect
    logic    jump;      // absolute redirect
    logic    sext;      // immediate extension fills with sign bit
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/rcore_ctrl.sv
module rcore_ctrl
  import rcore_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  // Don't-care table entries are resolved to 0 so unknown words stay inert.
  always_comb begin
    ctrl = '0;
    unique case (op)
      OP_RTYPE: begin
        if (funct == FN_ADD) begin
          ctrl.wr_rd  = 1'b1;
          ctrl.reg_we = 1'b1;
          ctrl.alu_op = ALU_ADD;
        end else if (funct == FN_SUB) begin
          ctrl.wr_rd  = 1'b1;
          ctrl.reg_we = 1'b1;
          ctrl.alu_op = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl.use_imm = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.sext    = 1'b0;
        ctrl.alu_op  = ALU_OR;
      end
      OP_LW: begin
        ctrl.use_imm  = 1'b1;
        ctrl.load_sel = 1'b1;
        ctrl.reg_we   = 1'b1;
        ctrl.sext     = 1'b1;
        ctrl.alu_op   = ALU_ADD;
      end
      OP_SW: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
        ctrl.sext    = 1'b1;
        ctrl.alu_op  = ALU_ADD;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_J: begin
        ctrl.jump = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile
  import rcore_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int WIDTH = XLEN
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] wa,
  input  logic [WIDTH-1:0]         wd,
  input  logic [$clog2(NREGS)-1:0] ra,
  input  logic [$clog2(NREGS)-1:0] rb,
  output logic [WIDTH-1:0]         rd_a,
  output logic [WIDTH-1:0]         rd_b
);

  localparam int IW = $clog2(NREGS);

  logic [WIDTH-1:0] bank [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign bank[i] = '0;
    end else begin : g_word
      logic             hit;
      logic [WIDTH-1:0] q;
      assign hit = we && (wa == IW'(i));
      always_ff @(posedge clk) begin
        if (hit) begin
          q <= wd;
        end
      end
      assign bank[i] = q;
    end
  end

  assign rd_a = bank[ra];
  assign rd_b = bank[rb];

endmodule

// File: rtl/rcore_exec.sv
module rcore_exec
  import rcore_pkg::*;
(
  input  logic [15:0]     imm16,
  input  logic            sext,
  input  logic            use_imm,
  input  alu_op_e         alu_op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] result,
  output logic            zero
);

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opnd_b;

  always_comb begin
    if (sext) begin
      imm_ext = {{(XLEN-16){imm16[15]}}, imm16};
    end else begin
      imm_ext = {{(XLEN-16){1'b0}}, imm16};
    end
    opnd_b = use_imm ? imm_ext : src_b;
  end

  always_comb begin
    result = '0;
    unique case (alu_op)
      ALU_ADD: result = src_a + opnd_b;
      ALU_SUB: result = src_a - opnd_b;
      ALU_OR:  result = src_a | opnd_b;
      default: result = '0;
    endcase
    zero = (result == '0);
  end

endmodule

// File: rtl/rcore_fetch.sv
module rcore_fetch
  import rcore_pkg::*;
(
  input  logic            clk,
  input  logic            rst_sync_n,
  input  logic            branch,
  input  logic            zero,
  input  logic            jump,
  input  logic [15:0]     imm16,
  input  logic [25:0]     target,
  output logic [XLEN-1:0] pc
);

  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] br_off;
  logic [XLEN-1:0] br_dest;
  logic [XLEN-1:0] jmp_dest;
  logic [XLEN-1:0] pc_next;

  always_comb begin
    pc_plus4 = pc + XLEN'(4);
    br_off   = {{(XLEN-18){imm16[15]}}, imm16, 2'b00};
    br_dest  = pc_plus4 + br_off;
    jmp_dest = {pc[XLEN-1:28], target, 2'b00};
    if (jump) begin
      pc_next = jmp_dest;
    end else if (branch && zero) begin
      pc_next = br_dest;
    end else begin
      pc_next = pc_plus4;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc <= '0;
    end else begin
      pc <= pc_next;
    end
  end

endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          imem_we,
  input  logic [$clog2(IMEM_WORDS)-1:0] imem_addr,
  input  logic [31:0]                   imem_wdata,
  output logic [31:0]                   dbg_pc,
  output logic                          dbg_wr_en,
  output logic [4:0]                    dbg_wr_idx,
  output logic [31:0]                   dbg_wr_data
);

  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  // Reset synchronizer: asserts at once, releases after two edges.
  logic [1:0] rst_q;
  logic [1:0] rst_q_next;
  logic       run;

  always_comb begin
    rst_q_next = {rst_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= rst_q_next;
    end
  end

  assign run = rst_q[1];

  // Instruction array
  logic [31:0]     imem [IMEM_WORDS];
  logic [XLEN-1:0] pc;
  logic [31:0]     instr;

  always_ff @(posedge clk) begin
    if (imem_we) begin
      imem[imem_addr] <= imem_wdata;
    end
  end

  assign instr = imem[pc[IAW+1:2]];

  // Field split
  logic [5:0]      f_op;
  logic [RIDX-1:0] f_rs;
  logic [RIDX-1:0] f_rt;
  logic [RIDX-1:0] f_rd;
  logic [5:0]      f_funct;
  logic [15:0]     f_imm;
  logic [25:0]     f_tgt;

  assign f_op    = instr[31:26];
  assign f_rs    = instr[25:21];
  assign f_rt    = instr[20:16];
  assign f_rd    = instr[15:11];
  assign f_funct = instr[5:0];
  assign f_imm   = instr[15:0];
  assign f_tgt   = instr[25:0];

  ctrl_t ctrl;

  rcore_ctrl u_ctrl (
    .op    (f_op),
    .funct (f_funct),
    .ctrl  (ctrl)
  );

  // Register bank
  logic            rf_we;
  logic [RIDX-1:0] rf_wa;
  logic [XLEN-1:0] rf_wd;
  logic [XLEN-1:0] bus_a;
  logic [XLEN-1:0] bus_b;

  rcore_regfile #(
    .NREGS (32),
    .WIDTH (XLEN)
  ) u_rf (
    .clk  (clk),
    .we   (rf_we),
    .wa   (rf_wa),
    .wd   (rf_wd),
    .ra   (f_rs),
    .rb   (f_rt),
    .rd_a (bus_a),
    .rd_b (bus_b)
  );

  // Execute
  logic [XLEN-1:0] alu_y;
  logic            alu_zero;

  rcore_exec u_exec (
    .imm16   (f_imm),
    .sext    (ctrl.sext),
    .use_imm (ctrl.use_imm),
    .alu_op  (ctrl.alu_op),
    .src_a   (bus_a),
    .src_b   (bus_b),
    .result  (alu_y),
    .zero    (alu_zero)
  );

  // Data array with range check above the word index
  logic [31:0]     dmem [DMEM_WORDS];
  logic [DAW-1:0]  d_idx;
  logic            d_in_range;
  logic            d_store;
  logic [XLEN-1:0] d_load;

  assign d_idx      = alu_y[DAW+1:2];
  assign d_in_range = (alu_y[XLEN-1:DAW+2] == '0);
  assign d_store    = run && ctrl.mem_we && d_in_range;
  assign d_load     = d_in_range ? dmem[d_idx] : '0;

  always_ff @(posedge clk) begin
    if (d_store) begin
      dmem[d_idx] <= bus_b;
    end
  end

  // Write-back
  assign rf_we = run && ctrl.reg_we;
  assign rf_wa = ctrl.wr_rd ? f_rd : f_rt;
  assign rf_wd = ctrl.load_sel ? d_load : alu_y;

  // Next address
  rcore_fetch u_fetch (
    .clk        (clk),
    .rst_sync_n (run),
    .branch     (ctrl.branch),
    .zero       (alu_zero),
    .jump       (ctrl.jump),
    .imm16      (f_imm),
    .target     (f_tgt),
    .pc         (pc)
  );

  assign dbg_pc      = pc;
  assign dbg_wr_en   = rf_we;
  assign dbg_wr_idx  = rf_wa;
  assign dbg_wr_data = rf_wd;

endmodule

// File: rtl/rcore_chk.sv
module rcore_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [31:0] instr,
  input logic [31:0] dbg_pc,
  input logic        dbg_wr_en,
  input logic [4:0]  dbg_wr_idx,
  input logic [31:0] dbg_wr_data
);

  logic [5:0] c_op;
  assign c_op = instr[31:26];

  // R9
  idle_in_reset_chk: assert property (@(posedge clk)
    !run |-> (!dbg_wr_en && dbg_pc == 32'd0));

  // R10
  pc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_pc[1:0] == 2'b00);

  // R8
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && c_op != 6'b000100 && c_op != 6'b000010)
    |=> dbg_pc == $past(dbg_pc) + 32'd4);

  // R6
  jump_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && c_op == 6'b000010)
    |=> dbg_pc == {$past(dbg_pc[31:28]), $past(instr[25:0]), 2'b00});

  // R6
  jump_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op == 6'b000010) |-> !dbg_wr_en);

  // R3
  store_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op == 6'b101011) |-> !dbg_wr_en);

  // R5
  branch_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op == 6'b000100) |-> !dbg_wr_en);

  // R2
  ori_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && c_op == 6'b001101)
    |-> (dbg_wr_en && dbg_wr_idx == instr[20:16]
         && (dbg_wr_data & {16'h0000, instr[15:0]}) == {16'h0000, instr[15:0]}));

endmodule

bind rcore_top rcore_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .instr       (instr),
  .dbg_pc      (dbg_pc),
  .dbg_wr_en   (dbg_wr_en),
  .dbg_wr_idx  (dbg_wr_idx),
  .dbg_wr_data (dbg_wr_data)
);

// File: tb/test_rcore_top.sv
module test_rcore_top;

  localparam int CLK_PERIOD = 10;
  localparam int IMEM_WORDS = 32;
  localparam int DMEM_WORDS = 16;
  localparam int IAW        = $clog2(IMEM_WORDS);

  localparam logic [5:0] K_ORI = 6'b001101;
  localparam logic [5:0] K_LW  = 6'b100011;
  localparam logic [5:0] K_SW  = 6'b101011;
  localparam logic [5:0] K_BEQ = 6'b000100;
  localparam logic [5:0] K_J   = 6'b000010;
  localparam logic [5:0] K_ADD = 6'b100000;
  localparam logic [5:0] K_SUB = 6'b100010;

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] tgt);
    return {op, tgt};
  endfunction

  localparam int NPROG = 24;
  localparam logic [31:0] PROG [NPROG] = '{
    enc_i(K_ORI, 5'd0, 5'd1, 16'h8005),   //  0
    enc_i(K_ORI, 5'd0, 5'd2, 16'h0003),   //  4
    enc_r(5'd1, 5'd2, 5'd3, K_ADD),       //  8
    enc_r(5'd2, 5'd1, 5'd4, K_SUB),       // 12
    enc_i(K_ORI, 5'd0, 5'd5, 16'h0040),   // 16
    enc_i(K_SW,  5'd5, 5'd3, 16'hFFFC),   // 20 store to 0x3C
    enc_i(K_LW,  5'd5, 5'd6, 16'hFFFC),   // 24
    enc_i(K_LW,  5'd0, 5'd7, 16'h003C),   // 28
    enc_i(K_BEQ, 5'd6, 5'd7, 16'd2),      // 32 taken to 44
    enc_i(K_ORI, 5'd0, 5'd8, 16'h0BAD),   // 36 skipped
    enc_i(K_ORI, 5'd0, 5'd8, 16'h0BAD),   // 40 skipped
    enc_i(K_BEQ, 5'd1, 5'd2, 16'd5),      // 44 not taken
    enc_r(5'd1, 5'd2, 5'd0, K_ADD),       // 48 write to r0
    enc_r(5'd0, 5'd2, 5'd9, K_ADD),       // 52
    enc_r(5'd1, 5'd2, 5'd10, 6'h25),      // 56 unknown funct
    enc_i(K_SW,  5'd0, 5'd1, 16'h007C),   // 60 out of range store
    enc_i(K_LW,  5'd0, 5'd12, 16'h003C),  // 64
    enc_i(K_LW,  5'd0, 5'd11, 16'h0040),  // 68 out of range load
    enc_j(K_J, 26'd22),                   // 72 to 88
    enc_i(K_ORI, 5'd0, 5'd8, 16'h0BAD),   // 76 skipped
    enc_i(K_ORI, 5'd0, 5'd8, 16'h0BAD),   // 80 skipped
    enc_i(K_ORI, 5'd0, 5'd8, 16'h0BAD),   // 84 skipped
    32'hFC000000,                         // 88 unknown opcode
    enc_i(K_BEQ, 5'd0, 5'd0, 16'hFFFF)    // 92 self loop
  };

  typedef struct packed {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  idx;
    logic [31:0] data;
    logic [23:0] tag;
  } step_t;

  localparam int NSTEP = 20;
  localparam step_t TRACE [NSTEP] = '{
    '{32'd0,  1'b1, 5'd1,  32'h0000_8005, "R2"},
    '{32'd4,  1'b1, 5'd2,  32'h0000_0003, "R2"},
    '{32'd8,  1'b1, 5'd3,  32'h0000_8008, "R1"},
    '{32'd12, 1'b1, 5'd4,  32'hFFFF_7FFE, "R1"},
    '{32'd16, 1'b1, 5'd5,  32'h0000_0040, "R2"},
    '{32'd20, 1'b0, 5'd0,  32'h0,         "R3"},
    '{32'd24, 1'b1, 5'd6,  32'h0000_8008, "R3"},
    '{32'd28, 1'b1, 5'd7,  32'h0000_8008, "R3"},
    '{32'd32, 1'b0, 5'd0,  32'h0,         "R5"},
    '{32'd44, 1'b0, 5'd0,  32'h0,         "R5"},
    '{32'd48, 1'b1, 5'd0,  32'h0000_8008, "R7"},
    '{32'd52, 1'b1, 5'd9,  32'h0000_0003, "R7"},
    '{32'd56, 1'b0, 5'd0,  32'h0,         "R8"},
    '{32'd60, 1'b0, 5'd0,  32'h0,         "R4"},
    '{32'd64, 1'b1, 5'd12, 32'h0000_8008, "R4"},
    '{32'd68, 1'b1, 5'd11, 32'h0000_0000, "R4"},
    '{32'd72, 1'b0, 5'd0,  32'h0,         "R6"},
    '{32'd88, 1'b0, 5'd0,  32'h0,         "R8"},
    '{32'd92, 1'b0, 5'd0,  32'h0,         "R5"},
    '{32'd92, 1'b0, 5'd0,  32'h0,         "R5"}
  };

  logic           clk;
  logic           rst_n;
  logic           imem_we;
  logic [IAW-1:0] imem_addr;
  logic [31:0]    imem_wdata;
  logic [31:0]    dbg_pc;
  logic           dbg_wr_en;
  logic [4:0]     dbg_wr_idx;
  logic [31:0]    dbg_wr_data;

  int  checks;
  int  errors;
  bit  done;

  rcore_top #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS)
  ) i_rcore_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .imem_we     (imem_we),
    .imem_addr   (imem_addr),
    .imem_wdata  (imem_wdata),
    .dbg_pc      (dbg_pc),
    .dbg_wr_en   (dbg_wr_en),
    .dbg_wr_idx  (dbg_wr_idx),
    .dbg_wr_data (dbg_wr_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_word(input logic [IAW-1:0] a, input logic [31:0] w);
    imem_we    = 1'b1;
    imem_addr  = a;
    imem_wdata = w;
    @(posedge clk);
    @(negedge clk);
    imem_we    = 1'b0;
  endtask

  task automatic next_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks     = 0;
    errors     = 0;
    done       = 1'b0;
    rst_n      = 1'b0;
    imem_we    = 1'b0;
    imem_addr  = '0;
    imem_wdata = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: idle during reset
    chk("R9", "pc in reset", dbg_pc, 32'd0);
    chk("R9", "wr_en in reset", {31'b0, dbg_wr_en}, 32'd0);

    // R11: preload program through the write port
    for (int k = 0; k < NPROG; k++) begin
      load_word(IAW'(k), PROG[k]);
    end

    rst_n = 1'b1;
    next_cycle();
    // R9: one edge after release still idle
    chk("R9", "pc one edge after release", dbg_pc, 32'd0);
    chk("R9", "wr_en one edge after release", {31'b0, dbg_wr_en}, 32'd0);
    next_cycle();

    for (int s = 0; s < NSTEP; s++) begin
      if (s > 0) next_cycle();
      chk($sformatf("%s", TRACE[s].tag), "pc (R10)", dbg_pc, TRACE[s].pc);
      chk($sformatf("%s", TRACE[s].tag), "wr_en (R10)",
          {31'b0, dbg_wr_en}, {31'b0, TRACE[s].we});
      if (TRACE[s].we) begin
        chk($sformatf("%s", TRACE[s].tag), "wr_idx",
            {27'b0, dbg_wr_idx}, {27'b0, TRACE[s].idx});
        chk($sformatf("%s", TRACE[s].tag), "wr_data",
            dbg_wr_data, TRACE[s].data);
      end
    end

    // R9: asynchronous reset mid-run clears PC at once
    rst_n = 1'b0;
    #1;
    chk("R9", "pc after mid-run reset", dbg_pc, 32'd0);
    chk("R9", "wr_en after mid-run reset", {31'b0, dbg_wr_en}, 32'd0);
    @(negedge clk);

    // R11: overwrite word 0 and observe it on the next run
    load_word('0, enc_i(K_ORI, 5'd0, 5'd13, 16'h1234));
    rst_n = 1'b1;
    next_cycle();
    chk("R9", "pc idle after second release", dbg_pc, 32'd0);
    next_cycle();
    chk("R11", "pc new word", dbg_pc, 32'd0);
    chk("R11", "wr_en new word", {31'b0, dbg_wr_en}, 32'd1);
    chk("R11", "wr_idx new word", {27'b0, dbg_wr_idx}, 32'd13);
    chk("R11", "wr_data new word", dbg_wr_data, 32'h0000_1234);
    next_cycle();
    chk("R2", "pc second word", dbg_pc, 32'd4);
    chk("R2", "wr_data second word", dbg_wr_data, 32'h0000_0003);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule